// File: doc/BRIEF.md
# Core/System Clock Ratio Generator

This block turns a single fast clock into two enable strobes. One marks core-clock ticks. The other marks system-clock ticks, which come at a selectable ratio of the core ticks. The core source is modelled in one of two ways. In the multiplied path, the core ticks follow the lock-ready signal of an external frequency multiplier. In the bypass path, the core ticks come on every second input clock.

A control register holds three things: the multiplier select, which is driven out to the external multiplier; the system divider select; and a bypass bit. While reset is high, the multiplier and divider defaults are taken from strap inputs.

Software writes the register, and each field obeys its own acceptance rule. The multiplier changes only while bypass is already in force, and only to a legal value. A new divider setting is held back until the running system period has finished, so no short period is produced. Four ratios are supported, one of them fractional (2.5).

Top module: `ratio_clkgen`

## Requirements
- R1: While `rst` is high, the multiplier select loads from `strap_mult_i` and the divider select from `strap_sdiv_i`. A strap multiplier of 0 or above 31 loads 1 instead. Bypass resets to 0, and both enables are 0.
- R2: With bypass clear, `cclk_en_o` equals `pll_lock_i` delayed by one clock. While lock is low, neither enable pulses.
- R3: Register bit 8 is the bypass bit. While it is set, `cclk_en_o` toggles on every clock, giving core ticks at half the input rate.
- R4: The divider code sits in register bits 13:12. Code 00 gives one `sclk_en_o` pulse per 2 core ticks, 01 one per 2.5, 10 one per 3, and 11 one per 4. Each pulse follows the core tick that completes the period by one clock.
- R5: At the 2.5 ratio, the spacing between system pulses alternates between 2 and 3 core ticks.
- R6: A write of a new divider code leaves the system period in progress unchanged. The new ratio starts with the following period.
- R7: The multiplier field (register bits 5:0) is updated by a write only if bypass was already set before that write. Otherwise it keeps its old value.
- R8: A written multiplier value of 0 or of 32 to 63 is ignored, and the previous value is kept.
- R9: Register readback `ctl_rd_o` shows the multiplier in bits 5:0, bypass in bit 8 and the most recently written divider code in bits 13:12. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| strap_mult_i | input | 6 | Multiplier default strap |
| strap_sdiv_i | input | 2 | Divider code default strap |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| pll_lock_i | input | 1 | Lock-ready from the external multiplier |
| ctl_rd_o | output | 16 | Register readback |
| mult_sel_o | output | 6 | Multiplier select to the external multiplier |
| bypass_o | output | 1 | Bypass currently in force |
| cclk_en_o | output | 1 | Core tick enable |
| sclk_en_o | output | 1 | System tick enable |

## Verification
The ratio generator is run with each of the four divider codes, in both the multiplied path and the bypass path. The pulses are counted over windows that are whole multiples of every period, so a wrong ratio and a missing bypass halving give different counts.

The fractional code is also checked pulse by pulse, which tells a true alternating 2/3 spacing apart from any even spacing that happens to give the same average. A divider change is written just after a system pulse of a divide-by-4 period. The gap measured next shows whether the old period was allowed to finish.

Multiplier writes are tried with bypass clear, with bypass set in the same write, and with bypass already set, using legal and illegal values. This separates the write-protect rule from the range rule.

// File: rtl/ratio_clkgen_pkg.sv
package ratio_clkgen_pkg;
  localparam int REG_W    = 16;
  localparam int BYP_BIT  = 8;
  localparam int SDIV_LSB = 12;
  localparam int SDIV_W   = 2;
  localparam int CNT_W    = 3;

  typedef enum logic [SDIV_W-1:0] {
    SDIV_2   = 2'd0,
    SDIV_2P5 = 2'd1,
    SDIV_3   = 2'd2,
    SDIV_4   = 2'd3
  } sdiv_e;

  // Core ticks in the current system period; phase picks the long half of 2.5
  function automatic logic [CNT_W-1:0] period_len(input sdiv_e code, input logic phase);
    case (code)
      SDIV_2:   return CNT_W'(2);
      SDIV_2P5: return phase ? CNT_W'(3) : CNT_W'(2);
      SDIV_3:   return CNT_W'(3);
      default:  return CNT_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/clkr_ctl_reg.sv
module clkr_ctl_reg
  import ratio_clkgen_pkg::*;
#(
  parameter int MULT_W    = 6,
  parameter int MULT_MAX  = 31,
  parameter int MULT_DFLT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MULT_W-1:0] strap_mult_i,
  input  logic [SDIV_W-1:0] strap_sdiv_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [MULT_W-1:0] mult_o,
  output logic              bypass_o,
  output sdiv_e             sdiv_req_o,
  output logic [REG_W-1:0]  rd_o
);
  logic [MULT_W-1:0] mult_q;
  logic              byp_q;
  sdiv_e             sdiv_q;
  logic [MULT_W-1:0] wr_mult;

  function automatic logic mult_ok(input logic [MULT_W-1:0] v);
    return (v != '0) && (int'(v) <= MULT_MAX);
  endfunction

  assign wr_mult = wr_data_i[MULT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mult_q <= mult_ok(strap_mult_i) ? strap_mult_i : MULT_W'(MULT_DFLT);
      byp_q  <= 1'b0;
      sdiv_q <= sdiv_e'(strap_sdiv_i);
    end else if (wr_en_i) begin
      byp_q  <= wr_data_i[BYP_BIT];
      sdiv_q <= sdiv_e'(wr_data_i[SDIV_LSB +: SDIV_W]);
      // protected field: bypass must already be in force
      if (byp_q && mult_ok(wr_mult)) mult_q <= wr_mult;
    end
  end

  always_comb begin
    rd_o = '0;
    rd_o[MULT_W-1:0] = mult_q;
    rd_o[BYP_BIT] = byp_q;
    rd_o[SDIV_LSB +: SDIV_W] = sdiv_q;
  end

  assign mult_o     = mult_q;
  assign bypass_o   = byp_q;
  assign sdiv_req_o = sdiv_q;
endmodule

// File: rtl/clkr_core_tick.sv
module clkr_core_tick (
  input  logic clk,
  input  logic rst,
  input  logic bypass_i,
  input  logic pll_lock_i,
  output logic tick_o
);
  logic tick_q;

  always_ff @(posedge clk) begin
    if (rst)           tick_q <= 1'b0;
    else if (bypass_i) tick_q <= ~tick_q;   // half of the input rate
    else               tick_q <= pll_lock_i; // multiplied path gated by lock
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/clkr_sdiv.sv
module clkr_sdiv
  import ratio_clkgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [SDIV_W-1:0] strap_sdiv_i,
  input  sdiv_e             sdiv_req_i,
  output logic              sclk_en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  sdiv_e            act_q;
  logic             sclk_q;
  logic [CNT_W-1:0] last;

  assign last = period_len(act_q, phase_q) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      act_q   <= sdiv_e'(strap_sdiv_i);
      sclk_q  <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == last) begin
        cnt_q   <= '0;
        sclk_q  <= 1'b1;
        // new ratio only at a period boundary
        act_q   <= sdiv_req_i;
        phase_q <= (act_q == SDIV_2P5) ? ~phase_q : 1'b0;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
        sclk_q <= 1'b0;
      end
    end else begin
      sclk_q <= 1'b0;
    end
  end

  assign sclk_en_o = sclk_q;
endmodule

// File: rtl/ratio_clkgen.sv
module ratio_clkgen
  import ratio_clkgen_pkg::*;
#(
  parameter int MULT_W    = 6,
  parameter int MULT_MAX  = 31,
  parameter int MULT_DFLT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MULT_W-1:0] strap_mult_i,
  input  logic [1:0]        strap_sdiv_i,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_data_i,
  input  logic              pll_lock_i,
  output logic [15:0]       ctl_rd_o,
  output logic [MULT_W-1:0] mult_sel_o,
  output logic              bypass_o,
  output logic              cclk_en_o,
  output logic              sclk_en_o
);
  sdiv_e sdiv_req;
  logic  byp;
  logic  tick;

  clkr_ctl_reg #(
    .MULT_W(MULT_W), .MULT_MAX(MULT_MAX), .MULT_DFLT(MULT_DFLT)
  ) u_reg (
    .clk(clk), .rst(rst),
    .strap_mult_i(strap_mult_i), .strap_sdiv_i(strap_sdiv_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .mult_o(mult_sel_o), .bypass_o(byp),
    .sdiv_req_o(sdiv_req), .rd_o(ctl_rd_o)
  );

  clkr_core_tick u_tick (
    .clk(clk), .rst(rst), .bypass_i(byp),
    .pll_lock_i(pll_lock_i), .tick_o(tick)
  );

  clkr_sdiv u_sdiv (
    .clk(clk), .rst(rst), .tick_i(tick),
    .strap_sdiv_i(strap_sdiv_i), .sdiv_req_i(sdiv_req),
    .sclk_en_o(sclk_en_o)
  );

  assign bypass_o  = byp;
  assign cclk_en_o = tick;
endmodule

// File: rtl/ratio_clkgen_chk.sv
module ratio_clkgen_chk #(
  parameter int MULT_W   = 6,
  parameter int MULT_MAX = 31
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic              pll_lock_i,
  input logic [MULT_W-1:0] mult_sel_o,
  input logic              bypass_o,
  input logic              cclk_en_o,
  input logic              sclk_en_o
);
  AST_MULT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (mult_sel_o != '0) && (int'(mult_sel_o) <= MULT_MAX)); // R8

  AST_MULT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !bypass_o |=> $stable(mult_sel_o)); // R7

  AST_BYPASS_HALF: assert property (@(posedge clk) disable iff (rst)
    ($past(bypass_o) && !$past(rst)) |-> (cclk_en_o != $past(cclk_en_o))); // R3

  AST_LOCK_GATES: assert property (@(posedge clk) disable iff (rst)
    (!$past(bypass_o) && !$past(pll_lock_i) && !$past(rst)) |-> !cclk_en_o); // R2

  AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    sclk_en_o |-> $past(cclk_en_o)); // R4

  AST_SCLK_SPACED: assert property (@(posedge clk) disable iff (rst)
    sclk_en_o |=> !sclk_en_o); // R4
endmodule

bind ratio_clkgen ratio_clkgen_chk #(.MULT_W(MULT_W), .MULT_MAX(MULT_MAX)) u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .pll_lock_i(pll_lock_i),
  .mult_sel_o(mult_sel_o), .bypass_o(bypass_o),
  .cclk_en_o(cclk_en_o), .sclk_en_o(sclk_en_o)
);

// File: tb/ratio_clkgen_tb_top.sv
`timescale 1ns/1ps
module ratio_clkgen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  strap_mult = 6'd12;
  logic [1:0]  strap_sdiv = 2'd2;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        lock = 1'b0;
  logic [15:0] ctl_rd;
  logic [5:0]  mult_sel;
  logic        byp, cclk_en, sclk_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ratio_clkgen dut_i (
    .clk(clk), .rst(rst), .strap_mult_i(strap_mult), .strap_sdiv_i(strap_sdiv),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .pll_lock_i(lock),
    .ctl_rd_o(ctl_rd), .mult_sel_o(mult_sel), .bypass_o(byp),
    .cclk_en_o(cclk_en), .sclk_en_o(sclk_en)
  );

  // {bypass, divider code, window in clocks, expected system pulses}
  localparam int VEC [8][4] = '{
    '{0, 0,  60, 30}, '{0, 1,  60, 24}, '{0, 2,  60, 20}, '{0, 3,  60, 15},
    '{1, 0, 120, 30}, '{1, 1, 120, 24}, '{1, 2, 120, 20}, '{1, 3, 120, 15}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic count_sclk(input int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (sclk_en) c++; end
  endtask

  task automatic wait_pulse(output int t);
    do @(negedge clk); while (!sclk_en);
    t = cyc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, hi, pairs, t0, t1, t2, g_prev, g, alt_ok;
    // R1 reset with straps
    repeat (3) @(negedge clk);
    chk("R1 ctl after straps", ctl_rd, 16'h200C);
    chk("R1 mult_sel", mult_sel, 12);
    chk("R1 bypass", byp, 0);
    chk("R1 enables", {cclk_en, sclk_en}, 0);
    rst = 1'b0;

    // R2 lock low blocks all ticks
    repeat (2) @(negedge clk);
    hi = 0; c = 0;
    repeat (30) begin @(negedge clk); if (cclk_en) hi++; if (sclk_en) c++; end
    chk("R2 cclk with lock low", hi, 0);
    chk("R2 sclk with lock low", c, 0);
    lock = 1'b1;
    @(negedge clk);
    chk("R2 cclk one clock after lock", cclk_en, 1);

    // R4 ratio table, both paths
    for (int i = 0; i < 8; i++) begin
      wr(16'((VEC[i][0] << 8) | (VEC[i][1] << 12)));
      repeat (20) @(negedge clk);
      count_sclk(VEC[i][2], c);
      chk($sformatf("R4 byp=%0d code=%0d", VEC[i][0], VEC[i][1]), c, VEC[i][3]);
    end

    // R3 bypass halves the core rate
    wr(16'h0100);
    repeat (4) @(negedge clk);
    hi = 0; pairs = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cclk_en) begin hi++; if (k > 0 && g_prev == 1) pairs++; end
      g_prev = cclk_en;
    end
    chk("R3 core ticks in 20 clocks", hi, 10);
    chk("R3 back-to-back core ticks", pairs, 0);

    // R5 alternating spacing at 2.5
    wr(16'h1000);
    repeat (20) @(negedge clk);
    wait_pulse(t0);
    g_prev = 0; alt_ok = 1;
    for (int k = 0; k < 8; k++) begin
      wait_pulse(t1);
      g = t1 - t0; t0 = t1;
      if (g != 2 && g != 3) alt_ok = 0;
      if (k > 0 && g == g_prev) alt_ok = 0;
      g_prev = g;
    end
    chk("R5 2/3 alternation", alt_ok, 1);

    // R6 divider change waits for the period boundary
    wr(16'h3000);
    repeat (20) @(negedge clk);
    wait_pulse(t0);
    wr(16'h0000);
    chk("R6 readback shows new code", ctl_rd[13:12], 0);
    wait_pulse(t1);
    wait_pulse(t2);
    chk("R6 old period completes", t1 - t0, 4);
    chk("R6 new period", t2 - t1, 2);

    // R7 / R8 multiplier protection
    wr(16'h0109);
    chk("R7 mult kept when bypass set in same write", mult_sel, 12);
    chk("R7 bypass taken", byp, 1);
    wr(16'h0109);
    chk("R7 mult accepted in bypass", mult_sel, 9);
    wr(16'h0100);
    chk("R8 zero ignored", mult_sel, 9);
    wr(16'h0128);
    chk("R8 forty ignored", mult_sel, 9);
    wr(16'h011F);
    chk("R8 thirty-one accepted", mult_sel, 31);
    wr(16'h0007);
    chk("R7 accepted while leaving bypass", mult_sel, 7);
    wr(16'h0003);
    chk("R7 kept outside bypass", mult_sel, 7);

    // R9 readback of unused bits
    wr(16'hFFFF);
    chk("R9 readback", ctl_rd, 16'h3107);

    // R1 illegal strap multiplier, divide-by-4 strap
    strap_mult = 6'd0; strap_sdiv = 2'd3;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 illegal strap gives 1", mult_sel, 1);
    chk("R1 ctl after second reset", ctl_rd, 16'h3001);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    count_sclk(60, c);
    chk("R1 strap ratio 4", c, 15);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule